// File: doc/BRIEF.md
# Dual-MAC accumulator saturation unit

This block sits after the adders of a two-lane multiply-accumulate datapath. Each lane hands it an unsaturated sum that is wider than the 40-bit accumulator. The block fits that sum into 40 bits according to the selected arithmetic mode. It clamps signed fractional results to the signed 40-bit range, and it clamps unsigned results to the unsigned 40-bit range. When the mixed-mode flag is set, unsigned results wrap to 40 bits instead. A 32-bit wrap mode bounds the result to a sign-extended 32-bit value.

Each lane keeps a per-accumulator overflow flag and a sticky copy of it. The two lanes' overflow results are merged into a shared overflow bit V and a sticky VS bit. A lane that is not enabled in a cycle keeps its accumulator and its flag, and it contributes no overflow to V. An explicit synchronous clear empties the sticky flags. A mode code that is not defined raises an illegal-mode output and leaves all state untouched.

Top module: `mac_sat_dual`

## Requirements
- R1: After reset, both accumulators and the av0, av0s, av1, av1s, v, vs and illegal outputs are 0.
- R2: With mode 3'd0 (signed fractional), a sum above 0x7F_FFFF_FFFF stores 0x7F_FFFF_FFFF and a sum below -2^39 stores 0x80_0000_0000; either case sets that lane's saturation result. Any other sum stores its low 40 bits with no saturation.
- R3: With mode 3'd1 (unsigned fractional) or 3'd2 (unsigned integer) and mixed = 0, a negative sum stores 0 and a sum above 0xFF_FFFF_FFFF stores 0xFF_FFFF_FFFF; either case saturates. Any other sum is stored unchanged.
- R4: With mode 3'd1 or 3'd2 and mixed = 1, the low 40 bits of the sum are stored and no saturation is reported.
- R5: With mode 3'd3 (32-bit wrap), let H be sum bits 31 and above. If H is neither all ones nor all zeros, the lane stores 0xFF_8000_0000 when sum bit 39 is 1, or 0x00_7FFF_FFFF when bit 39 is 0, and it saturates. Otherwise the lane stores the low 32 bits sign-extended from bit 31. The mixed flag has no effect in this mode.
- R6: In mode 3'd3, a lane's multiplier-saturation input also sets that lane's saturation result.
- R7: A lane that is enabled with a legal mode updates its accumulator and writes its AV flag (av0 or av1) with the saturation result, one clock after the inputs. A lane that is disabled keeps its accumulator and its AV flag.
- R8: A lane's sticky flag (av0s or av1s) is set when that lane saturates. It is cleared only by clr_sticky. A saturation in the same cycle as the clear leaves the sticky flag set.
- R9: When at least one lane is enabled with a legal mode, v is written with the OR of the saturation results of the enabled lanes. A disabled lane contributes 0. Otherwise v holds its value. vs becomes 1 whenever either lane saturates, and it is cleared by clr_sticky under the same rule as R8.
- R10: Mode codes 3'd4 to 3'd7 are illegal. When any lane is enabled with such a code, illegal is 1 in the next cycle, and no accumulator, AV flag, v or sticky flag is set. In every other cycle illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sum0 | input | SUM_W | Unsaturated sum of lane 0, two's complement |
| sum1 | input | SUM_W | Unsaturated sum of lane 1, two's complement |
| mode | input | 3 | Saturation mode code |
| mixed | input | 1 | Mixed-mode flag: unsigned modes wrap instead of clamping |
| en0 | input | 1 | Lane 0 active this cycle |
| en1 | input | 1 | Lane 1 active this cycle |
| msat0 | input | 1 | Multiplier saturation of lane 0 (used in 32-bit wrap mode) |
| msat1 | input | 1 | Multiplier saturation of lane 1 (used in 32-bit wrap mode) |
| clr_sticky | input | 1 | Synchronous clear of av0s, av1s and vs |
| acc0 | output | 40 | Accumulator of lane 0 |
| acc1 | output | 40 | Accumulator of lane 1 |
| av0 | output | 1 | Lane 0 overflow flag |
| av0s | output | 1 | Lane 0 sticky overflow flag |
| av1 | output | 1 | Lane 1 overflow flag |
| av1s | output | 1 | Lane 1 sticky overflow flag |
| v | output | 1 | Merged overflow of both lanes |
| vs | output | 1 | Sticky merged overflow |
| illegal | output | 1 | Illegal mode code seen on an active lane |

## Verification
Every output of this block is a register that is loaded on the rising edge that samples the inputs. An accumulator, its AV flag, v, the sticky flags and illegal are therefore all due one clock after the stimulus. The bench changes the inputs 1 ns after a rising edge and updates its expected state at the next rising edge. It compares all outputs 1 ns after that edge, when none of them can move. Directed cases cover each clamp boundary, the 32-bit wrap limits, the clear racing a saturation, and the illegal codes. A fixed-seed random run then mixes modes, enables and magnitudes chosen around the 32-bit and 40-bit limits.

// File: rtl/mac_sat_dual.sv
module mac_sat_dual #(
  parameter int SUM_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sum0,
  input  logic [SUM_W-1:0] sum1,
  input  logic [2:0]       mode,
  input  logic             mixed,
  input  logic             en0,
  input  logic             en1,
  input  logic             msat0,
  input  logic             msat1,
  input  logic             clr_sticky,
  output logic [39:0]      acc0,
  output logic [39:0]      acc1,
  output logic             av0,
  output logic             av0s,
  output logic             av1,
  output logic             av1s,
  output logic             v,
  output logic             vs,
  output logic             illegal
);
  localparam logic [2:0] M_SFRAC = 3'd0;
  localparam logic [2:0] M_UFRAC = 3'd1;
  localparam logic [2:0] M_UINT  = 3'd2;
  localparam logic [2:0] M_W32   = 3'd3;
  localparam int TOP_W = SUM_W - 39;
  localparam int HI_W  = SUM_W - 31;

  function automatic logic [40:0] fit(input logic [SUM_W-1:0] s, input logic [2:0] m,
                                      input logic mx, input logic ms);
    logic [TOP_W-1:0] top;
    logic [HI_W-1:0]  hi;
    top = s[SUM_W-1:39];
    hi  = s[SUM_W-1:31];
    case (m)
      M_SFRAC:
        if (&top || ~|top) fit = {1'b0, s[39:0]};
        else if (s[SUM_W-1]) fit = {2'b11, 39'd0};
        else fit = {2'b10, {39{1'b1}}};
      M_UFRAC, M_UINT:
        if (mx) fit = {1'b0, s[39:0]};
        else if (s[SUM_W-1]) fit = {1'b1, 40'd0};
        else if (|s[SUM_W-2:40]) fit = {1'b1, {40{1'b1}}};
        else fit = {1'b0, s[39:0]};
      M_W32:
        if (&hi || ~|hi) fit = {ms, {8{s[31]}}, s[31:0]};
        else if (s[39]) fit = {1'b1, 8'hFF, 32'h8000_0000};
        else fit = {1'b1, 8'h00, 32'h7FFF_FFFF};
      default: fit = '0;
    endcase
  endfunction

  logic [40:0] r0, r1;
  logic        wr0, wr1, ov0, ov1;

  assign r0  = fit(sum0, mode, mixed, msat0);
  assign r1  = fit(sum1, mode, mixed, msat1);
  assign wr0 = en0 & ~mode[2];
  assign wr1 = en1 & ~mode[2];
  assign ov0 = wr0 & r0[40];
  assign ov1 = wr1 & r1[40];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc0 <= '0; acc1 <= '0;
      av0 <= 1'b0; av0s <= 1'b0; av1 <= 1'b0; av1s <= 1'b0;
      v <= 1'b0; vs <= 1'b0; illegal <= 1'b0;
    end else begin
      illegal <= (en0 | en1) & mode[2];
      if (wr0) begin
        acc0 <= r0[39:0];
        av0  <= r0[40];
      end
      if (wr1) begin
        acc1 <= r1[39:0];
        av1  <= r1[40];
      end
      if (wr0 | wr1) v <= ov0 | ov1;
      av0s <= (av0s & ~clr_sticky) | ov0;
      av1s <= (av1s & ~clr_sticky) | ov1;
      vs   <= (vs & ~clr_sticky) | ov0 | ov1;
    end
  end
endmodule

module mac_sat_dual_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode,
  input logic        en0,
  input logic        en1,
  input logic        clr_sticky,
  input logic [39:0] acc0,
  input logic [39:0] acc1,
  input logic        av0,
  input logic        av0s,
  input logic        av1,
  input logic        av1s,
  input logic        v,
  input logic        vs,
  input logic        illegal
);
  assert_sticky_set0_R8: assert property (@(posedge clk) disable iff (!rst_n) $rose(av0) |-> av0s);
  assert_sticky_set1_R8: assert property (@(posedge clk) disable iff (!rst_n) $rose(av1) |-> av1s);
  assert_sticky_keep0_R8: assert property (@(posedge clk) disable iff (!rst_n) $fell(av0s) |-> $past(clr_sticky));
  assert_sticky_keep1_R8: assert property (@(posedge clk) disable iff (!rst_n) $fell(av1s) |-> $past(clr_sticky));
  assert_vs_with_v_R9: assert property (@(posedge clk) disable iff (!rst_n) $rose(v) |-> vs);
  assert_v_idle_R9: assert property (@(posedge clk) disable iff (!rst_n) $past(!en0 && !en1) |-> $stable(v));
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n) $past(!en0) |-> $stable(acc0));
  assert_illegal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(acc0) && $stable(acc1) && $stable(av0) && $stable(av1) && $stable(v)));
  assert_w32_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en0 && mode == 3'd3) |-> (&acc0[39:31] || ~|acc0[39:31]));
endmodule

bind mac_sat_dual mac_sat_dual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .en0(en0), .en1(en1), .clr_sticky(clr_sticky),
  .acc0(acc0), .acc1(acc1), .av0(av0), .av0s(av0s), .av1(av1), .av1s(av1s),
  .v(v), .vs(vs), .illegal(illegal)
);

// File: tb/test_mac_sat_dual.sv
`timescale 1ns/1ps
module test_mac_sat_dual;
  localparam int SUM_W = 48;
  logic clk = 0, rst_n = 0;
  logic [SUM_W-1:0] sum0 = '0, sum1 = '0;
  logic [2:0] mode = '0;
  logic mixed = 0, en0 = 0, en1 = 0, msat0 = 0, msat1 = 0, clr_sticky = 0;
  logic [39:0] acc0, acc1;
  logic av0, av0s, av1, av1s, v, vs, illegal;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [39:0] e_acc0 = 0, e_acc1 = 0;
  logic e_av0 = 0, e_av0s = 0, e_av1 = 0, e_av1s = 0, e_v = 0, e_vs = 0, e_ill = 0;

  always #2.5 clk = ~clk;

  mac_sat_dual #(.SUM_W(SUM_W)) i_mac_sat_dual (
    .clk(clk), .rst_n(rst_n), .sum0(sum0), .sum1(sum1), .mode(mode), .mixed(mixed),
    .en0(en0), .en1(en1), .msat0(msat0), .msat1(msat1), .clr_sticky(clr_sticky),
    .acc0(acc0), .acc1(acc1), .av0(av0), .av0s(av0s), .av1(av1), .av1s(av1s),
    .v(v), .vs(vs), .illegal(illegal));

  function automatic logic [40:0] model(input logic [SUM_W-1:0] raw, input logic [2:0] m,
                                        input logic mx, input logic ms);
    longint s, t;
    s = longint'($signed(raw));
    case (m)
      3'd0: begin
        if (s > 64'sh7F_FFFF_FFFF) return {1'b1, 40'h7F_FFFF_FFFF};
        if (s < -64'sh80_0000_0000) return {1'b1, 40'h80_0000_0000};
        return {1'b0, s[39:0]};
      end
      3'd1, 3'd2: begin
        if (mx) return {1'b0, s[39:0]};
        if (s < 0) return {1'b1, 40'h0};
        if (s > 64'shFF_FFFF_FFFF) return {1'b1, 40'hFF_FFFF_FFFF};
        return {1'b0, s[39:0]};
      end
      3'd3: begin
        t = s >>> 31;
        if (t != 0 && t != -1) return s[39] ? {1'b1, 40'hFF_8000_0000} : {1'b1, 40'h00_7FFF_FFFF};
        t = longint'($signed(s[31:0]));
        return {ms, t[39:0]};
      end
      default: return '0;
    endcase
  endfunction

  function automatic string mtag(input logic [2:0] m, input logic mx);
    if (m == 3'd0) return "R2";
    if (m == 3'd3) return "R5";
    if (m[2]) return "R10";
    return mx ? "R4" : "R3";
  endfunction

  task automatic chk(input string tag, input string name, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic check_all(input string t);
    chk(t, "acc0", 64'(acc0), 64'(e_acc0));
    chk(t, "acc1", 64'(acc1), 64'(e_acc1));
    chk("R7", "av0", 64'(av0), 64'(e_av0));
    chk("R7", "av1", 64'(av1), 64'(e_av1));
    chk("R8", "av0s", 64'(av0s), 64'(e_av0s));
    chk("R8", "av1s", 64'(av1s), 64'(e_av1s));
    chk("R9", "v", 64'(v), 64'(e_v));
    chk("R9", "vs", 64'(vs), 64'(e_vs));
    chk("R10", "illegal", 64'(illegal), 64'(e_ill));
  endtask

  task automatic step(input logic [SUM_W-1:0] s0, input logic [SUM_W-1:0] s1, input logic [2:0] m,
                      input logic mx, input logic e0, input logic e1,
                      input logic ms0, input logic ms1, input logic clr);
    logic [40:0] r0, r1;
    logic w0, w1, o0, o1;
    string t;
    sum0 = s0; sum1 = s1; mode = m; mixed = mx; en0 = e0; en1 = e1;
    msat0 = ms0; msat1 = ms1; clr_sticky = clr;
    r0 = model(s0, m, mx, ms0);
    r1 = model(s1, m, mx, ms1);
    w0 = e0 && m < 3'd4;
    w1 = e1 && m < 3'd4;
    o0 = w0 && r0[40];
    o1 = w1 && r1[40];
    t = mtag(m, mx);
    @(posedge clk);
    e_ill = (e0 || e1) && m >= 3'd4;
    if (w0) begin e_acc0 = r0[39:0]; e_av0 = r0[40]; end
    if (w1) begin e_acc1 = r1[39:0]; e_av1 = r1[40]; end
    if (w0 || w1) e_v = o0 || o1;
    e_av0s = (e_av0s && !clr) || o0;
    e_av1s = (e_av1s && !clr) || o1;
    e_vs = (e_vs && !clr) || o0 || o1;
    #1;
    check_all(t);
  endtask

  function automatic logic [SUM_W-1:0] rnd_sum();
    logic [63:0] r;
    r = {$urandom, $urandom};
    r = r >> ($urandom % 34);
    if ($urandom % 2) r = -r;
    return r[SUM_W-1:0];
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R1 reset state
    chk("R1", "acc0", 64'(acc0), 0); chk("R1", "acc1", 64'(acc1), 0);
    chk("R1", "flags", 64'({av0, av0s, av1, av1s, v, vs, illegal}), 0);
    // R2 signed clamps and in-range
    step(48'h0080_0000_0000, 48'hFF7F_FFFF_FFFF, 3'd0, 0, 1, 1, 0, 0, 0);
    step(48'h007F_FFFF_FFFF, 48'hFF80_0000_0000, 3'd0, 0, 1, 1, 0, 0, 0);
    // R8 clear without saturation empties sticky flags
    step(48'h1, 48'h2, 3'd0, 0, 1, 1, 0, 0, 1);
    // R3 unsigned clamps
    step(48'hFFFF_FFFF_FFFF, 48'h0100_0000_0000, 3'd1, 0, 1, 1, 0, 0, 0);
    step(48'h00FF_FFFF_FFFF, 48'h0, 3'd2, 0, 1, 1, 0, 0, 1);
    // R4 mixed wraps
    step(48'hFFFF_FFFF_FFFF, 48'h0123_4567_89AB, 3'd2, 1, 1, 1, 0, 0, 0);
    // R5 wrap-mode limits and sign extension
    step(48'h0080_0000_0000, 48'h0000_8000_0000, 3'd3, 0, 1, 1, 0, 0, 1);
    step(48'h0000_7FFF_FFFF, 48'hFFFF_8000_0000, 3'd3, 1, 1, 1, 0, 0, 1);
    // R6 multiplier saturation in wrap mode only
    step(48'h5, 48'h5, 3'd3, 0, 1, 1, 1, 0, 1);
    step(48'h5, 48'h5, 3'd0, 0, 1, 1, 1, 1, 1);
    // R7 / R9 disabled lane keeps state, contributes nothing
    step(48'h0100_0000_0000, 48'h7, 3'd0, 0, 0, 1, 0, 0, 1);
    step(48'h3, 48'h3, 3'd0, 0, 0, 0, 0, 0, 0);
    // R8 clear racing a saturation
    step(48'h0100_0000_0000, 48'h3, 3'd0, 0, 1, 1, 0, 0, 1);
    // R10 illegal codes
    step(48'h0100_0000_0000, 48'h0100_0000_0000, 3'd5, 0, 1, 1, 0, 0, 0);
    step(48'h9, 48'h9, 3'd7, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      step(rnd_sum(), rnd_sum(), 3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 4 != 0),
           1'($urandom % 4 != 0), 1'($urandom % 8 == 0), 1'($urandom % 8 == 0),
           1'($urandom % 16 == 0));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule